// File: doc/BRIEF.md
# MMU Fault Status Register Unit

This block keeps the three software-visible registers that a translation unit updates when an access goes wrong: a fault status word, a fault address register and a tag access register. A fault strobe carries the fault class, the address-space identifier (ASI), a write flag and a side-effect flag. The block folds these into a fresh status word. If the previous fault was still marked valid, the new word records an overflow. A separate miss strobe carries a virtual address and a context, which are packed into the tag access register. The TLB lookup itself and the translation-table pointer arithmetic live elsewhere.

Software reaches the registers through a simple offset-addressed port with an enable, a write flag and write data. Read data and an error flag are returned combinationally in the same cycle. Offset 0x0 gives a read-only repacked view of the tag access register, called the tag-target view. The parameter `DATA_SIDE` selects the data-side variant, which also holds the fault address. The instruction-side variant leaves that register out.

Top module: `mmu_fsr_unit`

## Requirements
- R1: After reset, the status, fault address and tag access registers all read as zero, and so does the tag-target view.
- R2: When a fault strobe arrives while status bit 0 is clear, the status word becomes: bit 0 = 1, bit 1 = 0, bit 2 = write flag, bit 6 = side-effect flag, bits 13..7 = fault type, bits 23..16 = ASI. All other bits are zero.
- R3: When a fault strobe arrives while status bit 0 is set, the word is built as in R2 except that bits 1..0 are 0b11.
- R4: In the data-side variant, every fault strobe loads its full 64-bit virtual address into the fault address register, which is read at offset 0x20. No other event changes that register.
- R5: A miss strobe loads the tag access register with virtual address bits 63..13 above context bits 12..0.
- R6: A read at offset 0x0 returns tag access bits 63..22 in result bits 41..0 and tag access bits 12..0 in result bits 60..48. All other result bits are zero.
- R7: A software write at offset 0x18 replaces the status word, and a write at offset 0x30 replaces the tag access register, with the full 64-bit data. A write to 0x18 that sets bit 0 counts as a valid prior fault for R3.
- R8: When a software write and a hardware capture target the same register in the same cycle, the software write wins. The fault address capture still happens.
- R9: An access to any offset other than 0x0, 0x18, 0x20 or 0x30 sets the error output and changes no register. So does a write to 0x0 or to 0x20. Read data is zero except during a valid read.
- R10: In the instruction-side variant, offset 0x20 is undefined and is handled as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_stb | input | 1 | Fault capture strobe |
| flt_type | input | 7 | Fault class code |
| flt_asi | input | 8 | ASI of the faulting access |
| flt_write | input | 1 | Faulting access was a store |
| flt_side | input | 1 | Faulting page has side effects |
| flt_va | input | 64 | Faulting virtual address |
| miss_stb | input | 1 | Tag capture strobe |
| miss_va | input | 64 | Virtual address of the miss |
| miss_ctx | input | 13 | Context of the miss |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | Register access is a write |
| reg_off | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| reg_err | output | 1 | Access to an undefined or read-only offset |

## Verification
The bench targets a fault that lands while bit 0 is already set, including when bit 0 was set by software. A design that ignored the prior state would show 0b01 where 0b11 belongs. It drives a software write and a capture in the same cycle; a wrong priority shows up as hardware values where the written data should be. It also hits writes to the read-only offsets and to undefined offsets. A decoder that accepted them would silently corrupt the tag or fault address registers, which later reads expose. Finally, it compares the tag-target view against an independent shift-and-mask formula, so any slip in the field positions appears as a miscompare.

// File: rtl/mmu_fsr_pkg.sv
package mmu_fsr_pkg;
  localparam int FSR_W       = 64;
  localparam int CTX_W       = 13;
  localparam int FT_W        = 7;
  localparam int ASI_W       = 8;
  localparam int OFF_W       = 12;
  localparam int WR_BIT      = 2;
  localparam int SE_BIT      = 6;
  localparam int FT_LSB      = 7;
  localparam int ASI_LSB     = 16;
  localparam int TT_VA_SHIFT = 22;
  localparam int TT_CTX_LSB  = 48;

  localparam logic [OFF_W-1:0] OFF_TT  = OFF_W'(12'h000);
  localparam logic [OFF_W-1:0] OFF_STS = OFF_W'(12'h018);
  localparam logic [OFF_W-1:0] OFF_FAR = OFF_W'(12'h020);
  localparam logic [OFF_W-1:0] OFF_TAG = OFF_W'(12'h030);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TT,
    SEL_STS,
    SEL_FAR,
    SEL_TAG
  } rd_sel_e;

  // Fresh status word; prior valid bit turns into the overflow mark.
  function automatic logic [FSR_W-1:0] fsr_compose(
    input logic             prev_valid,
    input logic [FT_W-1:0]  ft,
    input logic [ASI_W-1:0] asi,
    input logic             wr,
    input logic             se
  );
    logic [FSR_W-1:0] w;
    w                  = '0;
    w[0]               = 1'b1;
    w[1]               = prev_valid;
    w[WR_BIT]          = wr;
    w[SE_BIT]          = se;
    w[FT_LSB +: FT_W]  = ft;
    w[ASI_LSB +: ASI_W] = asi;
    return w;
  endfunction

  function automatic logic [FSR_W-1:0] tag_compose(
    input logic [FSR_W-1:0] va,
    input logic [CTX_W-1:0] ctx
  );
    return {va[FSR_W-1:CTX_W], ctx};
  endfunction

  function automatic logic [FSR_W-1:0] tag_target(input logic [FSR_W-1:0] ta);
    logic [FSR_W-1:0] t;
    t = ta >> TT_VA_SHIFT;
    t[TT_CTX_LSB +: CTX_W] = ta[CTX_W-1:0];
    return t;
  endfunction
endpackage

// File: rtl/fsr_reg_decode.sv
module fsr_reg_decode
  import mmu_fsr_pkg::*;
#(
  parameter bit DATA_SIDE = 1'b1
) (
  input  logic             en_i,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  output rd_sel_e          sel_o,
  output logic             sts_we_o,
  output logic             tag_we_o,
  output logic             err_o
);
  always_comb begin
    sel_o    = SEL_NONE;
    sts_we_o = 1'b0;
    tag_we_o = 1'b0;
    err_o    = 1'b0;
    if (en_i) begin
      case (off_i)
        OFF_TT: begin
          if (we_i) err_o = 1'b1;
          else      sel_o = SEL_TT;
        end
        OFF_STS: begin
          if (we_i) sts_we_o = 1'b1;
          else      sel_o    = SEL_STS;
        end
        OFF_FAR: begin
          if (we_i || !DATA_SIDE) err_o = 1'b1;
          else                    sel_o = SEL_FAR;
        end
        OFF_TAG: begin
          if (we_i) tag_we_o = 1'b1;
          else      sel_o    = SEL_TAG;
        end
        default: err_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
  import mmu_fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [FT_W-1:0]  ft_i,
  input  logic [ASI_W-1:0] asi_i,
  input  logic             wr_i,
  input  logic             se_i,
  input  logic             sw_we_i,
  input  logic [FSR_W-1:0] sw_data_i,
  output logic [FSR_W-1:0] sts_o,
  output logic             ovf_evt_o
);
  logic [FSR_W-1:0] sts_q;
  logic             cap_take;

  assign cap_take  = cap_i && !sw_we_i;
  assign ovf_evt_o = cap_take && sts_q[0];
  assign sts_o     = sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sw_we_i) begin
      sts_q <= sw_data_i;
    end else if (cap_take) begin
      sts_q <= fsr_compose(sts_q[0], ft_i, asi_i, wr_i, se_i);
    end
  end
endmodule

// File: rtl/fsr_tag_reg.sv
module fsr_tag_reg
  import mmu_fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [FSR_W-1:0] va_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic             sw_we_i,
  input  logic [FSR_W-1:0] sw_data_i,
  output logic [FSR_W-1:0] tag_o
);
  logic [FSR_W-1:0] tag_q;

  assign tag_o = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (sw_we_i) begin
      tag_q <= sw_data_i;
    end else if (cap_i) begin
      tag_q <= tag_compose(va_i, ctx_i);
    end
  end
endmodule

// File: rtl/fsr_far_reg.sv
module fsr_far_reg
  import mmu_fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [FSR_W-1:0] va_i,
  output logic [FSR_W-1:0] far_o
);
  logic [FSR_W-1:0] far_q;

  assign far_o = far_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     far_q <= '0;
    else if (cap_i) far_q <= va_i;
  end
endmodule

// File: rtl/mmu_fsr_unit.sv
module mmu_fsr_unit
  import mmu_fsr_pkg::*;
#(
  parameter bit DATA_SIDE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_stb,
  input  logic [FT_W-1:0]  flt_type,
  input  logic [ASI_W-1:0] flt_asi,
  input  logic             flt_write,
  input  logic             flt_side,
  input  logic [FSR_W-1:0] flt_va,
  input  logic             miss_stb,
  input  logic [FSR_W-1:0] miss_va,
  input  logic [CTX_W-1:0] miss_ctx,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [OFF_W-1:0] reg_off,
  input  logic [FSR_W-1:0] reg_wdata,
  output logic [FSR_W-1:0] reg_rdata,
  output logic             reg_err
);
  rd_sel_e          rd_sel;
  logic             sts_we;
  logic             tag_we;
  logic             acc_err;
  logic             ovf_evt;
  logic [FSR_W-1:0] sts_q;
  logic [FSR_W-1:0] tag_q;
  logic [FSR_W-1:0] far_q;
  logic [FSR_W-1:0] tt_view;

  fsr_reg_decode #(.DATA_SIDE(DATA_SIDE)) dec_i (
    .en_i     (reg_en),
    .we_i     (reg_we),
    .off_i    (reg_off),
    .sel_o    (rd_sel),
    .sts_we_o (sts_we),
    .tag_we_o (tag_we),
    .err_o    (acc_err)
  );

  fsr_status_reg sts_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (flt_stb),
    .ft_i      (flt_type),
    .asi_i     (flt_asi),
    .wr_i      (flt_write),
    .se_i      (flt_side),
    .sw_we_i   (sts_we),
    .sw_data_i (reg_wdata),
    .sts_o     (sts_q),
    .ovf_evt_o (ovf_evt)
  );

  fsr_tag_reg tag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (miss_stb),
    .va_i      (miss_va),
    .ctx_i     (miss_ctx),
    .sw_we_i   (tag_we),
    .sw_data_i (reg_wdata),
    .tag_o     (tag_q)
  );

  generate
    if (DATA_SIDE) begin : g_far
      fsr_far_reg far_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (flt_stb),
        .va_i  (flt_va),
        .far_o (far_q)
      );
    end else begin : g_no_far
      assign far_q = '0;
    end
  endgenerate

  assign tt_view = tag_target(tag_q);

  always_comb begin
    case (rd_sel)
      SEL_TT:  reg_rdata = tt_view;
      SEL_STS: reg_rdata = sts_q;
      SEL_FAR: reg_rdata = far_q;
      SEL_TAG: reg_rdata = tag_q;
      default: reg_rdata = '0;
    endcase
  end

  assign reg_err = acc_err;
endmodule

// File: rtl/mmu_fsr_unit_chk.sv
module mmu_fsr_unit_chk
  import mmu_fsr_pkg::*;
#(
  parameter bit DATA_SIDE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_stb,
  input logic [FSR_W-1:0] flt_va,
  input logic             miss_stb,
  input logic [CTX_W-1:0] miss_ctx,
  input logic             reg_en,
  input logic [FSR_W-1:0] reg_wdata,
  input logic [FSR_W-1:0] reg_rdata,
  input logic             reg_err,
  input logic             sts_we,
  input logic             tag_we,
  input logic             ovf_evt,
  input logic [FSR_W-1:0] sts_q,
  input logic [FSR_W-1:0] tag_q,
  input logic [FSR_W-1:0] far_q
);
  AST_FIRST_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_stb && !sts_we && !sts_q[0]) |=> (sts_q[1:0] == 2'b01)); // R2
  AST_OVF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (sts_q[1:0] == 2'b11)); // R3
  AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (DATA_SIDE && flt_stb) |=> (far_q == $past(flt_va))); // R4
  AST_FAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_stb |=> $stable(far_q)); // R4
  AST_TAG_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_stb && !tag_we) |=> (tag_q[CTX_W-1:0] == $past(miss_ctx))); // R5
  AST_SW_STS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> (sts_q == $past(reg_wdata))); // R8
  AST_SW_TAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> (tag_q == $past(reg_wdata))); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_err && !flt_stb && !miss_stb) |=> ($stable(sts_q) && $stable(tag_q))); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> (reg_rdata == '0)); // R9
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> !reg_err); // R9
endmodule

bind mmu_fsr_unit mmu_fsr_unit_chk #(.DATA_SIDE(DATA_SIDE)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .flt_stb   (flt_stb),
  .flt_va    (flt_va),
  .miss_stb  (miss_stb),
  .miss_ctx  (miss_ctx),
  .reg_en    (reg_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reg_err   (reg_err),
  .sts_we    (sts_we),
  .tag_we    (tag_we),
  .ovf_evt   (ovf_evt),
  .sts_q     (sts_q),
  .tag_q     (tag_q),
  .far_q     (far_q)
);

// File: tb/mmu_fsr_unit_tb_top.sv
module mmu_fsr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_stb = 1'b0;
  logic [6:0]  flt_type = '0;
  logic [7:0]  flt_asi = '0;
  logic        flt_write = 1'b0;
  logic        flt_side = 1'b0;
  logic [63:0] flt_va = '0;
  logic        miss_stb = 1'b0;
  logic [63:0] miss_va = '0;
  logic [12:0] miss_ctx = '0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_off = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] rd_d, rd_i;
  logic        er_d, er_i;

  int vectors = 0;
  int fails = 0;
  logic [63:0] m_sts = '0, m_tag = '0, m_far = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_fsr_unit #(.DATA_SIDE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_type(flt_type),
    .flt_asi(flt_asi), .flt_write(flt_write), .flt_side(flt_side),
    .flt_va(flt_va), .miss_stb(miss_stb), .miss_va(miss_va),
    .miss_ctx(miss_ctx), .reg_en(reg_en), .reg_we(reg_we),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(rd_d),
    .reg_err(er_d)
  );

  mmu_fsr_unit #(.DATA_SIDE(1'b0)) dut_ins_i (
    .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_type(flt_type),
    .flt_asi(flt_asi), .flt_write(flt_write), .flt_side(flt_side),
    .flt_va(flt_va), .miss_stb(miss_stb), .miss_va(miss_va),
    .miss_ctx(miss_ctx), .reg_en(reg_en), .reg_we(reg_we),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(rd_i),
    .reg_err(er_i)
  );

  function automatic logic [63:0] exp_status(input logic [63:0] prev,
      input logic [6:0] ft, input logic [7:0] asi, input bit wr, input bit se);
    logic [63:0] v;
    v = prev[0] ? 64'd3 : 64'd1;
    v = v + (wr ? 64'd4 : 64'd0) + (se ? 64'd64 : 64'd0);
    v = v + (64'(ft) * 64'd128) + (64'(asi) * 64'd65536);
    return v;
  endfunction

  function automatic logic [63:0] exp_tag(input logic [63:0] va, input logic [12:0] ctx);
    return (va & ~64'h1FFF) | 64'(ctx);
  endfunction

  function automatic logic [63:0] exp_tt(input logic [63:0] ta);
    return (ta >> 22) | ((ta & 64'h1FFF) << 48);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs checked before the edge, model updated after.
  task automatic step(input bit f, input logic [6:0] ft, input logic [7:0] asi,
      input bit wr, input bit se, input logic [63:0] fva, input bit m,
      input logic [63:0] mva, input logic [12:0] mctx, input bit en, input bit we,
      input logic [11:0] off, input logic [63:0] wd, input string lbl);
    bit ed, ei, vread;
    logic [63:0] xd, xi;
    @(negedge clk);
    flt_stb = f; flt_type = ft; flt_asi = asi; flt_write = wr; flt_side = se;
    flt_va = fva; miss_stb = m; miss_va = mva; miss_ctx = mctx;
    reg_en = en; reg_we = we; reg_off = off; reg_wdata = wd;
    vread = (off == 12'h000) || (off == 12'h018) || (off == 12'h020) || (off == 12'h030);
    ed = en && (!vread || (we && (off == 12'h000 || off == 12'h020)));
    ei = ed || (en && off == 12'h020);
    xd = '0; xi = '0;
    if (en && !we && !ed) begin
      case (off)
        12'h000: xd = exp_tt(m_tag);
        12'h018: xd = m_sts;
        12'h020: xd = m_far;
        default: xd = m_tag;
      endcase
    end
    if (en && !we && !ei) xi = xd;
    #1;
    chk(er_d == ed, lbl, "data-side err", 64'(er_d), 64'(ed));
    chk(rd_d == xd, lbl, "data-side rdata", rd_d, xd);
    chk(er_i == ei, (off == 12'h020) ? "R10" : lbl, "instr-side err", 64'(er_i), 64'(ei));
    chk(rd_i == xi, (off == 12'h020) ? "R10" : lbl, "instr-side rdata", rd_i, xi);
    @(posedge clk);
    #1;
    if (en && we && off == 12'h018)      m_sts = wd;
    else if (f)                          m_sts = exp_status(m_sts, ft, asi, wr, se);
    if (f)                               m_far = fva;
    if (en && we && off == 12'h030)      m_tag = wd;
    else if (m)                          m_tag = exp_tag(mva, mctx);
    flt_stb = 0; miss_stb = 0; reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] off, input string lbl);
    step(0, '0, '0, 0, 0, '0, 0, '0, '0, 1, 0, off, '0, lbl);
  endtask

  task automatic wrr(input logic [11:0] off, input logic [63:0] d, input string lbl);
    step(0, '0, '0, 0, 0, '0, 0, '0, '0, 1, 1, off, d, lbl);
  endtask

  task automatic flt(input logic [6:0] ft, input logic [7:0] asi, input bit w,
                     input bit s, input logic [63:0] va);
    step(1, ft, asi, w, s, va, 0, '0, '0, 0, 0, '0, '0, "R2");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] offs [5];
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    rd(12'h000, "R1"); rd(12'h018, "R1"); rd(12'h020, "R1"); rd(12'h030, "R1");
    // R2 then R3
    flt(7'h05, 8'h80, 1, 0, 64'hFFFF_8000_1234_5678);
    rd(12'h018, "R2"); rd(12'h020, "R4");
    flt(7'h7F, 8'hFF, 0, 1, 64'h0000_0000_0000_0ABC);
    rd(12'h018, "R3"); rd(12'h020, "R4");
    // R7: clear status, new fault is first again
    wrr(12'h018, 64'h0, "R7"); rd(12'h018, "R7");
    flt(7'h02, 8'h14, 0, 0, 64'h1);
    rd(12'h018, "R2");
    // software-set valid bit then fault gives overflow
    wrr(12'h018, 64'h1, "R7");
    flt(7'h03, 8'h04, 1, 1, 64'h2);
    rd(12'h018, "R3");
    // R5 / R6
    step(0, '0, '0, 0, 0, '0, 1, 64'hDEAD_BEEF_CAFE_F00D, 13'h1ABC, 0, 0, '0, '0, "R5");
    rd(12'h030, "R5"); rd(12'h000, "R6");
    wrr(12'h030, 64'h0123_4567_89AB_CDEF, "R7");
    rd(12'h030, "R7"); rd(12'h000, "R6");
    // R8: collisions
    step(1, 7'h11, 8'h22, 1, 1, 64'h5555_AAAA_5555_AAAA, 0, '0, '0, 1, 1,
         12'h018, 64'hA5A5_0000_0000_5A5A, "R8");
    rd(12'h018, "R8"); rd(12'h020, "R8");
    step(0, '0, '0, 0, 0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 13'h1FFF, 1, 1,
         12'h030, 64'h0000_1111_2222_3333, "R8");
    rd(12'h030, "R8");
    // R9 / R10
    wrr(12'h040, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    wrr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    wrr(12'h020, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    rd(12'h7FF, "R9"); rd(12'h019, "R9");
    rd(12'h018, "R9"); rd(12'h020, "R10"); rd(12'h030, "R9"); rd(12'h000, "R9");
    // constrained random mix
    offs[0] = 12'h000; offs[1] = 12'h018; offs[2] = 12'h020; offs[3] = 12'h030;
    for (int i = 0; i < 600; i++) begin
      bit f, m, en, we;
      logic [11:0] off;
      f  = ($urandom % 4) == 0;
      m  = ($urandom % 4) == 0;
      en = ($urandom % 4) != 0;
      we = ($urandom % 3) == 0;
      offs[4] = 12'($urandom);
      off = offs[$urandom % 5];
      step(f, 7'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
           {$urandom, $urandom}, m, {$urandom, $urandom}, 13'($urandom),
           en, we, off, {$urandom, $urandom}, "R7");
    end
    summary();
    $finish;
  end
endmodule